// File: doc/BRIEF.md
# Byte-Programmed CRC-16 Generator

This peripheral computes a 16-bit cyclic redundancy check over a stream of bytes that software pushes through an 8-bit register port. Two byte addresses expose one 16-bit register that is both the seed and the running result. Offset 0 is the upper byte and offset 1 is the lower byte. Software seeds the register by writing offset 0 and then offset 1. After that, every further write to offset 1 is a message byte that is folded into the checksum.

The checksum uses the polynomial 0x1021 (x^16 + x^12 + x^5 + 1). Bits are taken most significant first. The block applies no bit reflection and no final inversion. Each message byte is absorbed one bit per clock, so a byte takes eight cycles. While that happens, `busy` is high and any new write is held off by pulling `bus_ready` low. Reads are never held off and always show the live register contents.

Top module: `crc16_byte_periph`

## Requirements
- R1: After reset, both register bytes read 0x00, `busy` is 0 and `bus_ready` is 1.
- R2: A write accepted at offset 0 places the written byte into bits 15:8 unchanged. It performs no checksum step and leaves bits 7:0 as they were.
- R3: The first offset-1 write accepted after an offset-0 write is a seed byte. It goes unchanged into bits 7:0, leaves bits 15:8 alone and does not raise `busy`.
- R4: An offset-1 write accepted while no seed byte is pending is a message byte. It updates the register as CRC-16 with polynomial 0x1021, MSB first, with no reflection and no final XOR.
- R5: While `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows bits 15:8 for `bus_addr`=0 and bits 7:0 for `bus_addr`=1, in the same cycle. At all other times `bus_rdata` is 0x00.
- R6: `busy` rises on the clock edge that accepts a message byte and stays high for exactly 8 cycles. On the edge where it falls, the updated checksum is readable.
- R7: While `busy` is 1, a write sees `bus_ready`=0 and changes nothing until the byte in progress completes; reads keep `bus_ready`=1. Once the byte completes, the held write is taken with its normal effect.
- R8: Message bytes written after reset without any seeding are processed as if the seed were 0x0000.
- R9: Seeding 0xFFFF and then writing the ASCII bytes "123456789" leaves 0x29B1 in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Byte offset: 0 = bits 15:8, 1 = bits 7:0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is selected |
| bus_ready | output | 1 | Access is taken on a clock edge where it is 1 |
| busy | output | 1 | A message byte is being absorbed |

## Verification
Suppose the seed-pending flag is wrong. Then a seed byte gets mixed in as data, or a data byte gets loaded raw. Either way, the low byte read back right after the access is wrong, with no delay. A flaw in the shift step or in the bit order shows up only in the value read after the eight busy cycles. A flaw in busy counting shows up as a premature or late `busy` edge, or as a stalled write that lands inside the shift.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int unsigned BYTE_W_DEF = 8;
  localparam logic [15:0] POLY_DEF  = 16'h1021;

  localparam logic ADDR_UPPER = 1'b0;
  localparam logic ADDR_LOWER = 1'b1;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_SEED_HI = 2'd1,
    ACC_SEED_LO = 2'd2,
    ACC_DATA    = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/crc16_rst_sync.sv
module crc16_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/crc16_regif.sv
module crc16_regif
  import crc16_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      wr,
  input  logic      addr,
  input  logic      busy,
  output logic      ready,
  output acc_kind_e kind,
  output logic      seed_pending
);

  logic wr_fire;
  logic pend_d;
  logic pend_en;

  // writes are held while a byte is being absorbed; reads always pass
  assign ready   = !(sel && wr && busy);
  assign wr_fire = sel && wr && !busy;

  always_comb begin
    kind = ACC_NONE;
    if (wr_fire) begin
      if (addr == ADDR_UPPER) begin
        kind = ACC_SEED_HI;
      end else if (seed_pending) begin
        kind = ACC_SEED_LO;
      end else begin
        kind = ACC_DATA;
      end
    end
  end

  always_comb begin
    pend_en = wr_fire;
    pend_d  = (addr == ADDR_UPPER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_pending <= 1'b0;
    end else if (pend_en) begin
      seed_pending <= pend_d;
    end
  end

  assert_pending_after_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_SEED_HI) |=> seed_pending);

  assert_lower_consumes_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_SEED_LO) |=> (!seed_pending && (kind != ACC_SEED_LO)));

endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W_DEF,
  parameter logic [2*DATA_W-1:0] POLY = (2*DATA_W)'(POLY_DEF)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  acc_kind_e             kind,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   crc_q,
  output logic                  busy
);

  localparam int unsigned CRC_W = 2 * DATA_W;
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [CRC_W-1:0]  crc_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              reg_en;
  logic              fb;

  assign busy = (cnt_q != '0);
  assign fb   = crc_q[CRC_W-1] ^ dat_q[DATA_W-1];

  always_comb begin
    crc_d  = crc_q;
    dat_d  = dat_q;
    cnt_d  = cnt_q;
    reg_en = 1'b0;
    unique case (kind)
      ACC_SEED_HI: begin
        crc_d[CRC_W-1:DATA_W] = wdata;
        reg_en = 1'b1;
      end
      ACC_SEED_LO: begin
        crc_d[DATA_W-1:0] = wdata;
        reg_en = 1'b1;
      end
      ACC_DATA: begin
        dat_d  = wdata;
        cnt_d  = CNT_W'(DATA_W);
        reg_en = 1'b1;
      end
      default: begin
        if (busy) begin
          crc_d  = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
          dat_d  = {dat_q[DATA_W-2:0], 1'b0};
          cnt_d  = cnt_q - 1'b1;
          reg_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      dat_q <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      crc_q <= crc_d;
      dat_q <= dat_d;
      cnt_q <= cnt_d;
    end
  end

  assert_upper_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_SEED_HI) |=> ((crc_q[CRC_W-1:DATA_W] == $past(wdata)) &&
                               (crc_q[DATA_W-1:0] == $past(crc_q[DATA_W-1:0]))));

  assert_lower_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_SEED_LO) |=> ((crc_q[DATA_W-1:0] == $past(wdata)) &&
                               (crc_q[CRC_W-1:DATA_W] == $past(crc_q[CRC_W-1:DATA_W])) && !busy));

  assert_data_starts_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_DATA) |=> busy);

  assert_no_command_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (kind == ACC_NONE));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (kind == ACC_NONE)) |=> ($stable(crc_q) && !busy));

endmodule

// File: rtl/crc16_byte_periph.sv
module crc16_byte_periph
  import crc16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_ready,
  output logic       busy
);

  localparam int unsigned DATA_W = BYTE_W_DEF;
  localparam int unsigned CRC_W  = 2 * DATA_W;

  logic             srst_n;
  acc_kind_e        kind;
  logic             seed_pending;
  logic [CRC_W-1:0] crc_q;

  crc16_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  crc16_regif u_regif (
    .clk          (clk),
    .rst_n        (srst_n),
    .sel          (bus_sel),
    .wr           (bus_wr),
    .addr         (bus_addr),
    .busy         (busy),
    .ready        (bus_ready),
    .kind         (kind),
    .seed_pending (seed_pending)
  );

  crc16_engine #(
    .DATA_W (DATA_W),
    .POLY   (CRC_W'(POLY_DEF))
  ) u_engine (
    .clk   (clk),
    .rst_n (srst_n),
    .kind  (kind),
    .wdata (bus_wdata),
    .crc_q (crc_q),
    .busy  (busy)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      bus_rdata = (bus_addr == ADDR_UPPER) ? crc_q[CRC_W-1:DATA_W] : crc_q[DATA_W-1:0];
    end
  end

  assert_reads_never_stall_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && !bus_wr) |-> bus_ready);

  assert_idle_rdata_zero_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_crc16_byte_periph.sv
module tb_crc16_byte_periph;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr, bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_ready, busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_byte_periph dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .busy(busy)
  );

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f = r[15] ^ b[i];
      r = {r[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(1'b0, h);
    bus_read(1'b1, l);
    v = {h, l};
  endtask

  task automatic seed(input logic [15:0] s);
    bus_write(1'b0, s[15:8]);
    bus_write(1'b1, s[7:0]);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, exp;
    logic [7:0]  b;
    logic [15:0] seeds [4];
    string msg;
    seeds[0] = 16'h0000; seeds[1] = 16'hFFFF; seeds[2] = 16'h1D0F; seeds[3] = 16'h8001;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 ready", {15'd0, bus_ready}, 16'd1);
    read16(v);
    check("R1 reg", v, 16'h0000);

    // R5 idle rdata is zero
    #1 check("R5 idle rdata", {8'd0, bus_rdata}, 16'h0000);

    // R8 unseeded data byte behaves as seed 0
    bus_write(1'b1, 8'h31);
    wait_idle();
    read16(v);
    check("R8 unseeded", v, ref_byte(16'h0000, 8'h31));

    // R2 upper write alone; lower byte untouched
    exp = ref_byte(16'h0000, 8'h31);
    bus_write(1'b0, 8'hC3);
    check("R2 no busy", {15'd0, busy}, 16'd0);
    read16(v);
    check("R2 upper", v, {8'hC3, exp[7:0]});

    // R3 next lower write is seed, not data
    bus_write(1'b1, 8'h5A);
    check("R3 no busy", {15'd0, busy}, 16'd0);
    read16(v);
    check("R3 lower", v, 16'hC35A);

    // R6 busy duration for exactly 8 cycles
    bus_write(1'b1, 8'hE7);
    for (int i = 0; i < 8; i++) begin
      $sformat(msg, "R6 busy cycle %0d", i);
      check(msg, {15'd0, busy}, 16'd1);
      @(negedge clk);
    end
    check("R6 busy fell", {15'd0, busy}, 16'd0);
    read16(v);
    check("R6 result", v, ref_byte(16'hC35A, 8'hE7));

    // R7 reads pass while busy, writes stall then land
    exp = ref_byte(ref_byte(16'hC35A, 8'hE7), 8'h0F);
    bus_write(1'b1, 8'h0F);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
    #1 check("R7 read ready", {15'd0, bus_ready}, 16'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 8'hA5;
    #1 check("R7 write stalled", {15'd0, bus_ready}, 16'd0);
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    read16(v);
    check("R7 held write", v, {8'hA5, exp[7:0]});

    // R9 check value
    seed(16'hFFFF);
    for (int i = 0; i < 9; i++) begin
      bus_write(1'b1, 8'h31 + 8'(i));
      wait_idle();
    end
    read16(v);
    check("R9 check value", v, 16'h29B1);

    // R4 sweep: several seeds times every byte value
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 256; d++) begin
        b = 8'(d);
        seed(seeds[s]);
        bus_write(1'b1, b);
        wait_idle();
        read16(v);
        $sformat(msg, "R4 seed=%h byte=%h", seeds[s], b);
        check(msg, v, ref_byte(seeds[s], b));
      end
    end

    // R5 lower-offset read alone
    bus_read(1'b1, b);
    check("R5 lower read", {8'd0, b}, {8'd0, v[7:0]});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule